// File: doc/BRIEF.md
# Partitioned 8x16 SIMD Multiplier

This unit splits a pair of 64-bit operands into lanes and multiplies an 8-bit slice of the first operand by a signed 16-bit lane of the second. It does this in four lanes at once. Every product is rounded by looking at its bit 7. A 3-bit operation code picks how the lanes are paired. Five narrow variants write four rounded 16-bit results. Two double-width variants compute only the two low lanes and write each rounded product, unshifted, into a 32-bit half of the result.

The datapath has no clock between the operand inputs and the result register. When `in_valid` is high, the rounded, placed result is captured. `out_valid` rises on the following clock edge. Lanes are numbered from the least significant end: byte r is bits [8r+7:8r], 16-bit lane r is bits [16r+15:16r] and 32-bit lane r is bits [32r+31:32r].

Top module: `pmul8x16_unit`

## Requirements
- R1: Code 0 (direct): result lane r = round16(zero-extended byte r of `src_a` × signed 16-bit lane r of `src_b`), for r = 0..3.
- R2: Rounding. For a product p, the rounded value is q = p + 0x100 when bit 7 of p is 1, otherwise q = p. A narrow lane stores q[23:8]. This holds for negative products and for the byte values 0x80 and 0xFF.
- R3: Code 1: as R1, except every lane uses signed 16-bit lane 1 (bits [31:16]) of `src_b`.
- R4: Code 2: as R1, except every lane uses signed 16-bit lane 0 (bits [15:0]) of `src_b`.
- R5: Code 3: the multiplicand of lane r is the upper byte of 16-bit lane r of `src_a` (bits [16r+15:16r+8]), taken as signed. It is multiplied by signed lane r of `src_b` and stored as in R2.
- R6: Code 4: the multiplicand of lane r is the lower byte of 16-bit lane r of `src_a` (bits [16r+7:16r]), taken as unsigned. It is multiplied by signed lane r of `src_b`.
- R7: Codes 5 and 6 use the multiplicands of code 3 and code 4 respectively, for lanes 0 and 1 only. Each 32-bit result lane r holds the full rounded value q, sign-extended to 32 bits, without the 8-bit shift.
- R8: Code 7 is unused and yields an all-zero result.
- R9: The result is captured only on a clock edge where `in_valid` is 1. `out_valid` equals `in_valid` delayed by one cycle. With `in_valid` low, `result` holds its value.
- R10: While `rst` is high, and at the first edge after it falls if no input was strobed, `out_valid` is 0 and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operands and code |
| op_code | input | 3 | Lane pairing variant, 0..6; 7 unused |
| src_a | input | 64 | Operand supplying the 8-bit multiplicands |
| src_b | input | 64 | Operand supplying the signed 16-bit multipliers |
| out_valid | output | 1 | High for one cycle after each strobe |
| result | output | 64 | Registered, rounded and placed products |

## Verification
The properties assume that `op_code`, `src_a` and `src_b` are settled at every rising edge where `in_valid` is high. They also assume that reset is held long enough for one edge. The stimulus meets this by changing the inputs only on the falling clock edge. Reset is held for several cycles before the first strobe.

The operands are random, but they are biased toward negative 16-bit multipliers and toward multiplicand bytes of 0x00, 0x7F, 0x80 and 0xFF. This exercises the rounding and sign-extension boundaries in every variant. Back-to-back strobes and idle gaps are mixed, so the hold behaviour and the one-cycle valid delay are both exercised.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    parameter int WORD_W     = 64;
    parameter int BYTE_W     = 8;
    parameter int LANE_W     = 16;
    parameter int WIDE_W     = 32;

    localparam int NLANE      = WORD_W / LANE_W;
    localparam int WIDE_LANES = WORD_W / WIDE_W;
    localparam int MCAND_W    = BYTE_W + 1;
    localparam int PROD_W     = MCAND_W + LANE_W;
    localparam int RND_BIT    = BYTE_W - 1;

    typedef enum logic [2:0] {
        OP_DIRECT   = 3'd0,
        OP_BCAST_HI = 3'd1,
        OP_BCAST_LO = 3'd2,
        OP_PAIR_SHI = 3'd3,
        OP_PAIR_ULO = 3'd4,
        OP_WIDE_SHI = 3'd5,
        OP_WIDE_ULO = 3'd6,
        OP_NONE     = 3'd7
    } pmul_op_e;

    typedef struct packed {
        logic signed [MCAND_W-1:0] mcand;
        logic signed [LANE_W-1:0]  mplier;
    } lane_in_t;

    typedef logic signed [PROD_W-1:0] prod_t;

    function automatic logic op_is_wide(input pmul_op_e op);
        return (op == OP_WIDE_SHI) || (op == OP_WIDE_ULO);
    endfunction

    function automatic logic op_is_narrow(input pmul_op_e op);
        return (op == OP_DIRECT)   || (op == OP_BCAST_HI) ||
               (op == OP_BCAST_LO) || (op == OP_PAIR_SHI) ||
               (op == OP_PAIR_ULO);
    endfunction

    function automatic logic [WIDE_W-1:0] round_full(input prod_t p);
        logic [WIDE_W-1:0] ext;
        logic [WIDE_W-1:0] bump;
        ext  = {{(WIDE_W-PROD_W){p[PROD_W-1]}}, p};
        bump = p[RND_BIT] ? (WIDE_W'(1) << BYTE_W) : '0;
        return ext + bump;
    endfunction

    function automatic logic [LANE_W-1:0] round_narrow(input prod_t p);
        logic [WIDE_W-1:0] full;
        full = round_full(p);
        return full[BYTE_W +: LANE_W];
    endfunction

endpackage

// File: rtl/pmul_lane_select.sv
module pmul_lane_select
    import pmul_pkg::*;
(
    input  pmul_op_e                op,
    input  logic [WORD_W-1:0]       opa,
    input  logic [WORD_W-1:0]       opb,
    output lane_in_t [NLANE-1:0]    sel
);

    for (genvar r = 0; r < NLANE; r++) begin : g_sel
        localparam int BYTE_LO = r * BYTE_W;
        localparam int HALF_LO = r * LANE_W;
        localparam int HALF_HI = r * LANE_W + BYTE_W;

        logic [BYTE_W-1:0] byte_direct;
        logic [BYTE_W-1:0] byte_upper;
        logic [BYTE_W-1:0] byte_lower;
        logic [LANE_W-1:0] own_lane;

        assign byte_direct = opa[BYTE_LO +: BYTE_W];
        assign byte_upper  = opa[HALF_HI +: BYTE_W];
        assign byte_lower  = opa[HALF_LO +: BYTE_W];
        assign own_lane    = opb[HALF_LO +: LANE_W];

        always_comb begin
            sel[r] = '0;
            case (op)
                OP_DIRECT: begin
                    sel[r].mcand  = {1'b0, byte_direct};
                    sel[r].mplier = own_lane;
                end
                OP_BCAST_HI: begin
                    sel[r].mcand  = {1'b0, byte_direct};
                    sel[r].mplier = opb[LANE_W +: LANE_W];
                end
                OP_BCAST_LO: begin
                    sel[r].mcand  = {1'b0, byte_direct};
                    sel[r].mplier = opb[0 +: LANE_W];
                end
                OP_PAIR_SHI, OP_WIDE_SHI: begin
                    sel[r].mcand  = {byte_upper[BYTE_W-1], byte_upper};
                    sel[r].mplier = own_lane;
                end
                OP_PAIR_ULO, OP_WIDE_ULO: begin
                    sel[r].mcand  = {1'b0, byte_lower};
                    sel[r].mplier = own_lane;
                end
                default: sel[r] = '0;
            endcase
        end
    end

endmodule

// File: rtl/pmul_lane_mult.sv
module pmul_lane_mult
    import pmul_pkg::*;
(
    input  lane_in_t  lane_in,
    output prod_t     prod
);

    logic signed [MCAND_W-1:0] a_s;
    logic signed [LANE_W-1:0]  b_s;

    assign a_s  = lane_in.mcand;
    assign b_s  = lane_in.mplier;
    assign prod = a_s * b_s;

endmodule

// File: rtl/pmul_result_place.sv
module pmul_result_place
    import pmul_pkg::*;
(
    input  pmul_op_e               op,
    input  prod_t [NLANE-1:0]      prods,
    output logic [WORD_W-1:0]      placed
);

    logic [NLANE-1:0][LANE_W-1:0]      narrow;
    logic [WIDE_LANES-1:0][WIDE_W-1:0] wide;

    for (genvar r = 0; r < NLANE; r++) begin : g_narrow
        assign narrow[r] = round_narrow(prods[r]);
    end

    for (genvar r = 0; r < WIDE_LANES; r++) begin : g_wide
        assign wide[r] = round_full(prods[r]);
    end

    always_comb begin
        placed = '0;
        if (op_is_narrow(op)) begin
            for (int r = 0; r < NLANE; r++) begin
                placed[r*LANE_W +: LANE_W] = narrow[r];
            end
        end else if (op_is_wide(op)) begin
            for (int r = 0; r < WIDE_LANES; r++) begin
                placed[r*WIDE_W +: WIDE_W] = wide[r];
            end
        end
    end

endmodule

// File: rtl/pmul8x16_unit.sv
module pmul8x16_unit
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);

    pmul_op_e               op;
    lane_in_t [NLANE-1:0]   lanes;
    prod_t    [NLANE-1:0]   prods;
    logic [WORD_W-1:0]      placed;

    assign op = pmul_op_e'(op_code);

    pmul_lane_select u_select (
        .op  (op),
        .opa (src_a),
        .opb (src_b),
        .sel (lanes)
    );

    for (genvar r = 0; r < NLANE; r++) begin : g_lane
        pmul_lane_mult u_mult (
            .lane_in (lanes[r]),
            .prod    (prods[r])
        );
    end

    pmul_result_place u_place (
        .op     (op),
        .prods  (prods),
        .placed (placed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= placed;
            end
        end
    end

endmodule

// File: rtl/pmul8x16_unit_chk.sv
module pmul8x16_unit_chk
    import pmul_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        op_code,
    input logic [WORD_W-1:0] src_a,
    input logic [WORD_W-1:0] src_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R9

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R9

    AST_UNUSED_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == OP_NONE) |=> (result == '0)); // R8

    AST_ZERO_MULTIPLIER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == OP_DIRECT && src_b == '0) |=> (result == '0)); // R1

    AST_WIDE_ZERO_BYTES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_code == OP_WIDE_SHI || op_code == OP_WIDE_ULO) && src_a == '0)
        |=> (result == '0)); // R7

endmodule

bind pmul8x16_unit pmul8x16_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/pmul8x16_unit_test.sv
module pmul8x16_unit_test;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int          checks = 0;
    int          failures = 0;
    logic [63:0] last_exp = '0;
    bit          finished = 1'b0;
    sb_item_t    sb[$];

    always #10 clk = ~clk;

    pmul8x16_unit uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [63:0] model(input logic [2:0] op,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) begin
            longint      m;
            longint      w;
            longint      p;
            logic [63:0] pv;
            case (op)
                3'd0, 3'd1, 3'd2: m = longint'(a[8*k +: 8]);
                3'd3, 3'd5:       m = longint'($signed(a[16*k+8 +: 8]));
                3'd4, 3'd6:       m = longint'(a[16*k +: 8]);
                default:          m = 0;
            endcase
            if (op == 3'd1)      w = longint'($signed(b[31:16]));
            else if (op == 3'd2) w = longint'($signed(b[15:0]));
            else                 w = longint'($signed(b[16*k +: 16]));
            p  = m * w;
            pv = p;
            if (pv[7]) p = p + 256;
            pv = p;
            if (op <= 3'd4) r[16*k +: 16] = pv[23:8];
            else if (op <= 3'd6 && k < 2) r[32*k +: 32] = pv[31:0];
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [63:0] a,
                         input logic [63:0] b, input string tag);
        sb_item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op_code  = op;
        src_a    = a;
        src_b    = b;
        it.exp   = model(op, a, b);
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_code  = 3'($urandom);
            src_a    = {$urandom, $urandom};
            src_b    = {$urandom, $urandom};
        end
    endtask

    function automatic logic [7:0] pick_byte();
        case ($urandom % 6)
            0: return 8'h80;
            1: return 8'hFF;
            2: return 8'h7F;
            3: return 8'h00;
            default: return 8'($urandom);
        endcase
    endfunction

    function automatic logic [63:0] rand_a();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = pick_byte();
        return v;
    endfunction

    function automatic logic [63:0] rand_b();
        logic [63:0] v;
        v = {$urandom, $urandom};
        for (int i = 0; i < 4; i++) begin
            if ($urandom % 2 == 0) v[16*i + 15] = 1'b1;
        end
        return v;
    endfunction

    // Monitor: pops the scoreboard whenever the design flags a result
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R9 actual=out_valid_high expected=no_pending_item");
                end else begin
                    sb_item_t it;
                    it = sb.pop_front();
                    check_eq(it.tag, result, it.exp);
                    last_exp = it.exp;
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check_eq("R10", {63'd0, out_valid}, 64'd0);
        check_eq("R10", result, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R10", {63'd0, out_valid}, 64'd0);
        check_eq("R10", result, 64'd0);

        // R2: rounding boundaries in the direct variant
        drive(3'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0080, "R2");
        drive(3'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_007F, "R2");
        drive(3'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_FFFF, "R2");
        drive(3'd0, 64'hFF80_FF80_0180_FF01, 64'hFF80_8000_FFFF_7FFF, "R2");
        drive(3'd3, 64'h80FF_FF80_7F01_8080, 64'h8000_FFFF_0181_7FFF, "R2");
        drive(3'd5, 64'h0000_0000_FF00_8000, 64'h0000_0000_0081_8000, "R2");
        drive(3'd6, 64'h0000_0000_00FF_0080, 64'h0000_0000_FF7F_8001, "R2");
        idle(2);

        // R1: zero multiplier yields zero
        drive(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R1");
        // R8: unused code
        drive(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_8000_8000_8000, "R8");
        idle(1);

        // Every variant over random, boundary-biased operands
        for (int rep = 0; rep < 160; rep++) begin
            for (int op = 0; op < 8; op++) begin
                drive(3'(op), rand_a(), rand_b(), tag_of(3'(op)));
                if ($urandom % 4 == 0) idle(1 + $urandom % 2);
            end
        end

        // R9: result holds and valid stays low while idle
        idle(4);
        check_eq("R9", {63'd0, out_valid}, 64'd0);
        check_eq("R9", result, last_exp);
        idle(3);
        check_eq("R9", result, last_exp);
        check_eq("R9", 64'(sb.size()), 64'd0);

        finish_run();
    end

endmodule